// File: doc/BRIEF.md
# UART Channel Register Front-End

This block is the software-facing control core of one serial channel. It holds two mode registers reached through a self-advancing pointer, a status register, an interrupt status view and an interrupt mask, and it decodes a command register that starts and stops each direction and issues reset actions. Outgoing characters pass through a one-byte holding buffer. Incoming characters and line-break events arrive on a byte-wide parallel port and are queued in a four-entry receive FIFO. The bit shifter, baud clock and modem pins lie outside this block.

A processor reaches the block through a small register port: a single-cycle write strobe, or a read strobe with combinational read data. Register offsets are 0x00 for the mode registers, 0x04 for status (read), 0x08 for commands (write), 0x0C for receive data (read) and transmit data (write), and 0x14 for interrupt status (read) and the interrupt mask (write). Other offsets read as zero and ignore writes. A line-break event queues a zero byte even when the queue is full, in which case it replaces the newest entry.

Top module: `uart_fe`

## Requirements
- R1: After reset, status reads 0x08 (only transmitter-empty set), both mode registers, the interrupt status and the mask read 0x00, `irq` and `rx_ready` are low, and neither direction is enabled.
- R2: A read or write at offset 0x00 reaches mode register 1 until the first write there. After any such write it reaches mode register 2. A command whose bits 6:4 equal 1 points it back to mode register 1.
- R3: Status bit positions are: 0 receiver ready, 1 FIFO full, 2 transmitter ready, 3 transmitter empty, 4 overrun, 5 parity error, 6 framing error, 7 break received. Bits 7:4 always read 0. Transmitter ready equals the transmitter enable.
- R4: Command bits 3:2 control the transmitter and bits 1:0 the receiver. In both fields 1 enables, 2 disables, and 0 or 3 has no effect.
- R5: A write at 0x0C clears transmitter empty and loads the byte. If the transmitter is enabled, the byte appears on `tx_data` with `tx_valid` high for one cycle after that write, and empty sets again. If it is disabled, the byte is held and then sent when an enable command arrives.
- R6: A command with bits 6:4 equal to 3 disables the transmitter, discards any held byte, sets empty and clears ready.
- R7: A data byte is accepted only while the receiver is enabled and the FIFO is not full. This condition is shown on `rx_ready`. Receiver ready is set by any push, and full is set when four bytes are held.
- R8: A read at 0x0C returns the oldest byte and removes it, clears full, and clears receiver ready when the FIFO empties. A read of an empty FIFO returns 0x00 and changes nothing.
- R9: A break event pushes 0x00 whether or not the receiver is enabled. When the FIFO is full, the break overwrites the newest entry. It sets interrupt status bit 2, which a command with bits 6:4 equal to 5 clears.
- R10: A command with bits 6:4 equal to 2 disables the receiver and empties the FIFO, which clears receiver ready and full.
- R11: Interrupt status bit 0 equals transmitter ready. Bit 1 equals FIFO full when mode register 1 bit 6 is set, and receiver ready otherwise. Bit 7 reads 0.
- R12: `irq` is high exactly when some interrupt status bit and the same mask bit are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 5 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive data at 0x0C) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from the address |
| rx_valid | input | 1 | Received data byte present |
| rx_data | input | 8 | Received data byte |
| rx_break | input | 1 | Line-break event |
| rx_ready | output | 1 | Receiver enabled and FIFO not full |
| tx_valid | output | 1 | One-cycle strobe for an outgoing byte |
| tx_data | output | 8 | Outgoing byte |
| irq | output | 1 | Masked interrupt request |

## Verification
Every register, flag and the `tx_valid` strobe changes at the clock edge that captures a write, a read-pop, a received byte or a break. `reg_rdata`, `irq` and `rx_ready` are combinational from that stored state, so each result is due one edge after its stimulus. The bench drives each strobe for exactly one cycle starting at a falling edge and checks at the next falling edge, after the single capturing edge. Read data is sampled a short delay after the read strobe is applied, before the edge that performs the pop.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;
  // status bit positions
  localparam int ST_RXRDY = 0;
  localparam int ST_FULL  = 1;
  localparam int ST_TXRDY = 2;
  localparam int ST_TXEMP = 3;
  // interrupt status bit positions
  localparam int IS_TX  = 0;
  localparam int IS_RX  = 1;
  localparam int IS_BRK = 2;
  // mode register 1 bit selecting the receive interrupt source
  localparam int MR1_RXSEL = 6;

  typedef enum logic [2:0] {
    MISC_NOP    = 3'd0,
    MISC_PTRRST = 3'd1,
    MISC_RXRST  = 3'd2,
    MISC_TXRST  = 3'd3,
    MISC_BRKCLR = 3'd5
  } misc_cmd_e;

  typedef enum logic [1:0] {
    DIR_NOP = 2'd0,
    DIR_ON  = 2'd1,
    DIR_OFF = 2'd2,
    DIR_RSV = 2'd3
  } dir_cmd_e;

  typedef struct packed {
    misc_cmd_e misc;
    dir_cmd_e  tx;
    dir_cmd_e  rx;
  } cmd_t;

  function automatic cmd_t split_cmd(input logic [7:0] v);
    cmd_t c;
    c.misc = misc_cmd_e'(v[6:4]);
    c.tx   = dir_cmd_e'(v[3:2]);
    c.rx   = dir_cmd_e'(v[1:0]);
    return c;
  endfunction

  // new enable state after a direction field
  function automatic logic apply_dir(input logic cur, input dir_cmd_e d);
    case (d)
      DIR_ON:  return 1'b1;
      DIR_OFF: return 1'b0;
      default: return cur;
    endcase
  endfunction
endpackage

// File: rtl/uart_fe_rxfifo.sv
module uart_fe_rxfifo #(
  parameter int DEPTH = 4,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          not_empty
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] LAST_IDX = CW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [CW-1:0] cnt_q, after_pop, wr_idx, cnt_d;
  logic          do_pop;

  assign do_pop    = pop && (cnt_q != '0);
  assign after_pop = do_pop ? cnt_q - 1'b1 : cnt_q;
  // a push into a full queue replaces the newest entry
  assign wr_idx    = (after_pop == FULL_CNT) ? LAST_IDX : after_pop;
  assign cnt_d     = push ? ((after_pop == FULL_CNT) ? FULL_CNT : after_pop + 1'b1)
                          : after_pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (flush) cnt_q <= '0;
    else cnt_q <= cnt_d;
  end

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem[i] <= '0;
        else begin
          if (do_pop && i < DEPTH - 1) mem[i] <= mem[(i + 1) % DEPTH];
          if (push && wr_idx == CW'(i)) mem[i] <= push_data;
        end
      end
    end
  endgenerate

  assign head      = mem[0];
  assign count     = cnt_q;
  assign full      = (cnt_q == FULL_CNT);
  assign not_empty = (cnt_q != '0);

  // R7
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);
  // R10
  fifo_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == '0));
endmodule

// File: rtl/uart_fe_txctl.sv
module uart_fe_txctl
  import uart_fe_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  cmd_t          cmd,
  input  logic          data_wr,
  input  logic [DW-1:0] wdata,
  output logic          tx_en,
  output logic          tx_empty,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data
);
  logic          en_q, emp_q, en_d, emp_d, send;
  logic [DW-1:0] hold_q, hold_d;

  always_comb begin
    en_d   = en_q;
    emp_d  = emp_q;
    hold_d = hold_q;
    send   = 1'b0;
    if (cmd_wr) begin
      if (cmd.misc == MISC_TXRST) begin
        en_d  = 1'b0;
        emp_d = 1'b1;
      end
      en_d = apply_dir(en_d, cmd.tx);
      if (en_d && !emp_d) begin
        send  = 1'b1;
        emp_d = 1'b1;
      end
    end
    if (data_wr) begin
      hold_d = wdata;
      emp_d  = 1'b0;
      if (en_q) begin
        send  = 1'b1;
        emp_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      emp_q    <= 1'b1;
      hold_q   <= '0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      en_q     <= en_d;
      emp_q    <= emp_d;
      hold_q   <= hold_d;
      tx_valid <= send;
      if (send) tx_data <= hold_d;
    end
  end

  assign tx_en    = en_q;
  assign tx_empty = emp_q;

  // R5
  tx_sent_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> emp_q);
  // R6
  tx_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd.misc == MISC_TXRST && cmd.tx != DIR_ON) |=> (!en_q && emp_q));
endmodule

// File: rtl/uart_fe.sv
module uart_fe
  import uart_fe_pkg::*;
#(
  parameter int DW     = 8,
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_break,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              irq
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(5'h00);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(5'h04);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(5'h08);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(5'h0C);
  localparam logic [ADDR_W-1:0] A_INT  = ADDR_W'(5'h14);

  // named events for checking
  logic wr_mode, wr_cmd, wr_data, wr_mask, rd_data;
  logic pop_evt, push_evt, flush_evt, brk_clr_evt;
  cmd_t cmd;

  assign wr_mode = reg_wr && reg_addr == A_MODE;
  assign wr_cmd  = reg_wr && reg_addr == A_CMD;
  assign wr_data = reg_wr && reg_addr == A_DATA;
  assign wr_mask = reg_wr && reg_addr == A_INT;
  assign rd_data = reg_rd && reg_addr == A_DATA;
  assign cmd     = split_cmd(reg_wdata);

  logic [7:0] mr1_q, mr2_q, mask_q;
  logic       ptr_q, rx_en_q, brk_q;

  logic          fifo_full, fifo_ne;
  logic [CW-1:0] fifo_cnt;
  logic [DW-1:0] fifo_head;
  logic          tx_en, tx_empty;

  assign flush_evt   = wr_cmd && cmd.misc == MISC_RXRST;
  assign brk_clr_evt = wr_cmd && cmd.misc == MISC_BRKCLR;
  assign rx_ready    = rx_en_q && !fifo_full;
  assign push_evt    = rx_break || (rx_valid && rx_ready);
  assign pop_evt     = rd_data && fifo_ne;

  uart_fe_rxfifo #(.DEPTH(DEPTH), .DW(DW)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(flush_evt), .push(push_evt),
    .push_data(rx_break ? '0 : rx_data), .pop(pop_evt),
    .head(fifo_head), .count(fifo_cnt), .full(fifo_full), .not_empty(fifo_ne)
  );

  uart_fe_txctl #(.DW(DW)) u_tx (
    .clk(clk), .rst_n(rst_n), .cmd_wr(wr_cmd), .cmd(cmd), .data_wr(wr_data),
    .wdata(reg_wdata), .tx_en(tx_en), .tx_empty(tx_empty),
    .tx_valid(tx_valid), .tx_data(tx_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mr1_q   <= '0;
      mr2_q   <= '0;
      ptr_q   <= 1'b0;
      mask_q  <= '0;
      rx_en_q <= 1'b0;
      brk_q   <= 1'b0;
    end else begin
      if (wr_mode) begin
        if (ptr_q) mr2_q <= reg_wdata;
        else       mr1_q <= reg_wdata;
        ptr_q <= 1'b1;
      end
      if (wr_cmd && cmd.misc == MISC_PTRRST) ptr_q <= 1'b0;
      if (wr_mask) mask_q <= reg_wdata;
      if (wr_cmd)
        rx_en_q <= apply_dir(flush_evt ? 1'b0 : rx_en_q, cmd.rx);
      // a break in the same cycle as the clear wins
      if (rx_break)         brk_q <= 1'b1;
      else if (brk_clr_evt) brk_q <= 1'b0;
    end
  end

  logic [7:0] status, isr;
  always_comb begin
    status = '0;
    status[ST_RXRDY] = fifo_ne;
    status[ST_FULL]  = fifo_full;
    status[ST_TXRDY] = tx_en;
    status[ST_TXEMP] = tx_empty;
    isr = '0;
    isr[IS_TX]  = tx_en;
    isr[IS_RX]  = mr1_q[MR1_RXSEL] ? fifo_full : fifo_ne;
    isr[IS_BRK] = brk_q;
  end

  assign irq = |(isr & mask_q);

  always_comb begin
    case (reg_addr)
      A_MODE:  reg_rdata = ptr_q ? mr2_q : mr1_q;
      A_STAT:  reg_rdata = status;
      A_DATA:  reg_rdata = fifo_ne ? 8'(fifo_head) : 8'h00;
      A_INT:   reg_rdata = isr;
      default: reg_rdata = 8'h00;
    endcase
  end

  // R7
  rx_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !rx_break && !rd_data && !flush_evt)
      |=> $stable(fifo_cnt));
  // R8
  pop_clear_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_evt && !push_evt) |=> !fifo_full);
  // R9
  brk_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_break |=> brk_q);
  // R2
  ptr_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mode |=> ptr_q);
  // R12
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 8'h00) |-> !irq);
endmodule

// File: tb/uart_fe_test.sv
module uart_fe_test;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 0, rst_n = 0;
  logic [4:0] reg_addr = '0;
  logic       reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic       rx_valid = 0, rx_break = 0;
  logic [7:0] rx_data = '0;
  logic       rx_ready, tx_valid, irq;
  logic [7:0] tx_data;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_fe uut (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic rx_push(input logic [7:0] d);
    @(negedge clk); rx_data = d; rx_valid = 1;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic rx_brk();
    @(negedge clk); rx_break = 1;
    @(negedge clk); rx_break = 0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(5'h04, v); chk("R1 status", v, 8'h08);
    rd(5'h00, v); chk("R1 mode", v, 8'h00);
    rd(5'h14, v); chk("R1 isr", v, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 rx_ready", {7'd0, rx_ready}, 8'h00);
  endtask

  task automatic t_mode();
    logic [7:0] v;
    wr(5'h00, 8'h11);
    rd(5'h00, v); chk("R2 mr2 after first write", v, 8'h00);
    wr(5'h00, 8'h22);
    rd(5'h00, v); chk("R2 mr2 written", v, 8'h22);
    wr(5'h08, 8'h10);
    rd(5'h00, v); chk("R2 ptr reset", v, 8'h11);
  endtask

  task automatic t_tx();
    logic [7:0] v;
    wr(5'h0C, 8'h5A);
    chk("R5 held while disabled", {7'd0, tx_valid}, 8'h00);
    rd(5'h04, v); chk("R5 empty cleared", v, 8'h00);
    wr(5'h08, 8'h04);
    chk("R5 enable sends held", {7'd0, tx_valid}, 8'h01);
    chk("R5 held data", tx_data, 8'h5A);
    rd(5'h04, v); chk("R3 tx ready+empty", v, 8'h0C);
    wr(5'h0C, 8'hC3);
    chk("R5 direct send strobe", {7'd0, tx_valid}, 8'h01);
    chk("R5 direct send data", tx_data, 8'hC3);
    @(negedge clk);
    chk("R5 strobe one cycle", {7'd0, tx_valid}, 8'h00);
    wr(5'h08, 8'h08);
    rd(5'h04, v); chk("R4 tx disable", v, 8'h08);
    wr(5'h0C, 8'h11);
    wr(5'h08, 8'h30);
    rd(5'h04, v); chk("R6 tx reset sets empty", v, 8'h08);
    wr(5'h08, 8'h04);
    chk("R6 discarded byte not sent", {7'd0, tx_valid}, 8'h00);
    wr(5'h08, 8'h0C);
    rd(5'h04, v); chk("R4 reserved no effect", v & 8'h0C, 8'h0C);
    wr(5'h08, 8'h30);
  endtask

  task automatic t_rx();
    logic [7:0] v;
    rx_push(8'hEE);
    rd(5'h04, v); chk("R7 ignored while disabled", v & 8'h03, 8'h00);
    wr(5'h08, 8'h01);
    chk("R7 rx_ready enabled", {7'd0, rx_ready}, 8'h01);
    rx_push(8'hA1); rx_push(8'hA2); rx_push(8'hA3);
    rd(5'h04, v); chk("R7 ready not full", v & 8'h03, 8'h01);
    rx_push(8'hA4);
    rd(5'h04, v); chk("R7 full at four", v & 8'h03, 8'h03);
    chk("R7 rx_ready low when full", {7'd0, rx_ready}, 8'h00);
    rx_push(8'hA5);
    rd(5'h0C, v); chk("R8 pop 1", v, 8'hA1);
    rd(5'h04, v); chk("R8 full cleared", v & 8'h03, 8'h01);
    rd(5'h0C, v); chk("R8 pop 2", v, 8'hA2);
    rd(5'h0C, v); chk("R8 pop 3", v, 8'hA3);
    rd(5'h0C, v); chk("R7 rejected byte absent", v, 8'hA4);
    rd(5'h04, v); chk("R8 ready cleared empty", v & 8'h03, 8'h00);
    rd(5'h0C, v); chk("R8 empty read zero", v, 8'h00);
    rd(5'h04, v); chk("R8 empty read no change", v & 8'h03, 8'h00);
  endtask

  task automatic t_break();
    logic [7:0] v;
    rx_push(8'hB1); rx_push(8'hB2); rx_push(8'hB3); rx_push(8'hB4);
    rx_brk();
    rd(5'h14, v); chk("R9 break flag", v & 8'h04, 8'h04);
    rd(5'h0C, v); chk("R9 order 1", v, 8'hB1);
    rd(5'h0C, v); chk("R9 order 2", v, 8'hB2);
    rd(5'h0C, v); chk("R9 order 3", v, 8'hB3);
    rd(5'h0C, v); chk("R9 overwritten newest", v, 8'h00);
    wr(5'h08, 8'h50);
    rd(5'h14, v); chk("R9 break clear", v & 8'h04, 8'h00);
    wr(5'h08, 8'h02);
    rx_push(8'h77);
    rx_brk();
    rd(5'h04, v); chk("R9 break pushes when disabled", v & 8'h03, 8'h01);
    rd(5'h0C, v); chk("R9 break byte zero", v, 8'h00);
    wr(5'h08, 8'h50);
  endtask

  task automatic t_rxreset();
    logic [7:0] v;
    wr(5'h08, 8'h01);
    rx_push(8'hC1); rx_push(8'hC2);
    wr(5'h08, 8'h20);
    rd(5'h04, v); chk("R10 flush", v & 8'h03, 8'h00);
    chk("R10 rx disabled", {7'd0, rx_ready}, 8'h00);
    rd(5'h0C, v); chk("R10 empty after flush", v, 8'h00);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    wr(5'h14, 8'h02);
    chk("R12 no source", {7'd0, irq}, 8'h00);
    wr(5'h08, 8'h01);
    rx_push(8'hD1);
    rd(5'h14, v); chk("R11 rx from ready", v, 8'h02);
    chk("R12 rx irq", {7'd0, irq}, 8'h01);
    wr(5'h08, 8'h10);
    wr(5'h00, 8'h40);
    chk("R11 rx from full, not full", {7'd0, irq}, 8'h00);
    rx_push(8'hD2); rx_push(8'hD3); rx_push(8'hD4);
    chk("R11 rx from full", {7'd0, irq}, 8'h01);
    wr(5'h14, 8'h00);
    chk("R12 masked", {7'd0, irq}, 8'h00);
    wr(5'h08, 8'h04);
    rd(5'h14, v); chk("R11 tx int", v, 8'h03);
    wr(5'h14, 8'h01);
    chk("R12 tx irq", {7'd0, irq}, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_mode();
    t_tx();
    t_rx();
    t_break();
    t_rxreset();
    t_irq();
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk); cyc++;
    end
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule